// File: doc/BRIEF.md
# Cascadable LCD Segment Column Driver

This block is the digital core of an 80-column segment driver for a dot-matrix LCD panel. The display controller sends pixel data for a line on a data clock. In serial mode one bit arrives per falling edge. In parallel mode four bits arrive per falling edge. Serial bits are gathered into groups of four, and each complete group is written into a first latch. An address counter chooses the position of each write, so the first bit of a line lands on column 0 and later bits go to higher columns.

Several drivers can share one data stream. Each driver takes data only while its chain-disable input is low. Its chain output stays high until its own 80 columns are full and then drops. That output feeds the chain-disable input of the next driver, so the drivers fill in turn. On the falling edge of the line-load strobe the first latch is copied into a second latch, and the fill position is reset for the next line.

Each column drives a 2-bit level code. The code is chosen from the second-latch bit, a frame-alternation input and an active-low blanking input. All strobes are sampled on a fast system clock, and their falling edges are detected in that clock domain.

Top module: `lcd_seg_driver`

## Requirements
- R1: A synchronous active-low reset clears both latches, the fill position and the partial group, and drives the chain output high. With `alt` low and `blank_n` high, every column then shows code 01.
- R2: With `par_mode` low, each detected falling edge of `shift_clk` takes `ser_in` as one bit. The n-th bit of a line (n counted from 1) lands in column n-1, and column c occupies `drive_code[2c+1:2c]`. `par_in` has no effect in this mode.
- R3: With `par_mode` high, each detected falling edge takes `par_in` as one group of four. `par_in[0]` goes to the lowest column of the group, and groups fill columns in ascending order.
- R4: While `chain_dis_in` is high, falling edges of `shift_clk` change neither the first latch nor the fill position.
- R5: `chain_out` is high until all 80 columns of the current line have been taken, then it is low. Further data edges are ignored; they do not wrap to column 0.
- R6: Serial bits reach the first latch only in complete groups of four. A trailing partial group leaves its four columns at their previous values.
- R7: A falling edge of `line_load` copies the first latch into the second latch. The outputs show the new data one system clock later. The same edge clears the fill position and the partial group and sets `chain_out` high. The first latch itself keeps its contents.
- R8: With `blank_n` high, a column's code is 00 for alt=0 and bit 1, 01 for alt=0 and bit 0, 10 for alt=1 and bit 1, and 11 for alt=1 and bit 0.
- R9: With `blank_n` low, every column shows code 00, whatever the data or `alt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_clk | input | 1 | Data clock; data is taken on its falling edge |
| line_load | input | 1 | Line-load strobe; acts on its falling edge |
| par_mode | input | 1 | 1 = four-bit parallel input, 0 = serial input |
| ser_in | input | 1 | Serial data bit |
| par_in | input | 4 | Parallel data group; bit 0 goes to the lowest column |
| chain_dis_in | input | 1 | Chain disable; data is taken only while this is low |
| chain_out | output | 1 | High while this driver still takes data; feeds the next driver's chain disable |
| alt | input | 1 | Frame alternation select |
| blank_n | input | 1 | Active-low blanking; low forces code 00 on every column |
| drive_code | output | 160 | Two-bit level code per column; column c at bits [2c+1:2c] |

## Verification
The serial line uses an irregular bit pattern, with noise on the unused parallel pins, so that a reversed, shifted or wrapped fill order shows up. The parallel line uses distinct group values, which exposes a swapped group bit order or a wrong group position. Three boundary patterns follow: a line with extra bits past 80, a line sent while disabled, and a 78-bit line followed by a short line. These tell apart overflow wrap, ignored disable, a leaked partial group and a counter that was not cleared. The four combinations of `alt` and `blank_n` are then applied over a fixed second-latch content to cover every level code.

// File: rtl/lcd_seg_pkg.sv
// Shared types and level selection for the LCD segment driver.
// Assumes group width is a power of two.
package lcd_seg_pkg;

    localparam int GRP_W = 4;

    typedef enum logic [1:0] {
        LVL_SEL_LO   = 2'b00,
        LVL_UNSEL_LO = 2'b01,
        LVL_SEL_HI   = 2'b10,
        LVL_UNSEL_HI = 2'b11
    } drive_lvl_e;

    // Pick the level code for one column from its bit, alternation and blanking.
    function automatic drive_lvl_e pick_level(input logic pix, input logic alt, input logic blank_n);
        drive_lvl_e lvl;
        if (!blank_n)
            lvl = LVL_SEL_LO;
        else if (!alt)
            lvl = pix ? LVL_SEL_LO : LVL_UNSEL_LO;
        else
            lvl = pix ? LVL_SEL_HI : LVL_UNSEL_HI;
        return lvl;
    endfunction

endpackage

// File: rtl/lcd_seg_edge.sv
// Falling-edge detector for a slow strobe sampled on the system clock.
// Assumes the strobe is already synchronous to clk.
// One pulse per high-to-low change; a level held low gives no further pulse.
module lcd_seg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);

    logic lvl_q;

    // Remember the level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign fall = lvl_q & ~lvl;

endmodule

// File: rtl/lcd_seg_fill.sv
// Fill engine: position counter, serial group packer and first latch.
// Assumes COLS is a multiple of the group width.
// A line-load edge has priority over a data edge in the same cycle.
module lcd_seg_fill
    import lcd_seg_pkg::*;
#(
    parameter int COLS = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_fall,
    input  logic             load_fall,
    input  logic             par_mode,
    input  logic             ser_in,
    input  logic [GRP_W-1:0] par_in,
    input  logic             chain_dis_in,
    output logic             chain_out,
    output logic [COLS-1:0]  line_q
);

    localparam int CW = $clog2(COLS + 1);
    localparam int NB = $clog2(GRP_W);
    localparam int SW = CW - NB;

    logic [CW-1:0]    bit_cnt;
    logic [GRP_W-2:0] part;
    logic [SW-1:0]    slot;
    logic [NB-1:0]    pos;
    logic             full;
    logic             take;

    assign slot = bit_cnt[CW-1:NB];
    assign pos  = bit_cnt[NB-1:0];
    assign full = (bit_cnt >= CW'(COLS));
    assign take = data_fall & ~chain_dis_in & ~full;
    assign chain_out = ~full;

    // Advance the fill position and store complete groups into the first latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            part    <= '0;
            line_q  <= '0;
        end else if (load_fall) begin
            bit_cnt <= '0;
            part    <= '0;
        end else if (take) begin
            if (par_mode) begin
                line_q[int'(slot)*GRP_W +: GRP_W] <= par_in;
                bit_cnt <= {SW'(slot + 1'b1), {NB{1'b0}}};
                part    <= '0;
            end else begin
                if (pos == NB'(GRP_W - 1))
                    line_q[int'(slot)*GRP_W +: GRP_W] <= {ser_in, part};
                else
                    part[pos] <= ser_in;
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcd_seg_level.sv
// Second latch and per-column level decode.
// Assumes alt and blank_n are synchronous; the decode is combinational.
module lcd_seg_level
    import lcd_seg_pkg::*;
#(
    parameter int COLS = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_fall,
    input  logic [COLS-1:0]   line_q,
    input  logic              alt,
    input  logic              blank_n,
    output logic [2*COLS-1:0] drive_code
);

    logic [COLS-1:0] shown_q;

    // Capture the filled line on each line-load edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         shown_q <= '0;
        else if (load_fall) shown_q <= line_q;
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign drive_code[2*c +: 2] = pick_level(shown_q[c], alt, blank_n);
    end

endmodule

// File: rtl/lcd_seg_driver.sv
// Top of the cascadable LCD segment column driver.
// Samples the data clock and the load strobe on clk and acts on their falling edges.
// Assumes all inputs are synchronous to clk and each strobe level lasts at least one clk.
module lcd_seg_driver
    import lcd_seg_pkg::*;
#(
    parameter int COLS = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_clk,
    input  logic              line_load,
    input  logic              par_mode,
    input  logic              ser_in,
    input  logic [GRP_W-1:0]  par_in,
    input  logic              chain_dis_in,
    output logic              chain_out,
    input  logic              alt,
    input  logic              blank_n,
    output logic [2*COLS-1:0] drive_code
);

    logic            data_fall;
    logic            load_fall;
    logic [COLS-1:0] line_q;

    lcd_seg_edge u_data_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (shift_clk),
        .fall (data_fall)
    );

    lcd_seg_edge u_load_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (line_load),
        .fall (load_fall)
    );

    lcd_seg_fill #(.COLS(COLS)) u_fill (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_fall   (data_fall),
        .load_fall   (load_fall),
        .par_mode    (par_mode),
        .ser_in      (ser_in),
        .par_in      (par_in),
        .chain_dis_in(chain_dis_in),
        .chain_out   (chain_out),
        .line_q      (line_q)
    );

    lcd_seg_level #(.COLS(COLS)) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_fall (load_fall),
        .line_q    (line_q),
        .alt       (alt),
        .blank_n   (blank_n),
        .drive_code(drive_code)
    );

endmodule

// File: rtl/lcd_seg_driver_chk.sv
// Port-level checker for lcd_seg_driver, bound to every instance.
// Assumes the same synchronous active-low reset as the design.
module lcd_seg_driver_chk #(
    parameter int COLS = 80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shift_clk,
    input logic              line_load,
    input logic              chain_dis_in,
    input logic              chain_out,
    input logic              alt,
    input logic              blank_n,
    input logic [2*COLS-1:0] drive_code
);

    logic [COLS-1:0] code_msb;

    // Gather the upper bit of every column code.
    always_comb begin
        for (int c = 0; c < COLS; c++) code_msb[c] = drive_code[2*c+1];
    end

    // R9
    blank_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |-> (drive_code == '0));

    // R8
    alt_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank_n |-> (code_msb == {COLS{alt}}));

    // R5
    chain_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chain_out) |-> (!$past(shift_clk) && $past(shift_clk, 2) && !$past(chain_dis_in)));

    // R4
    chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_dis_in |=> !$fell(chain_out));

    // R7
    chain_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_out) |-> (!$past(line_load) && $past(line_load, 2)));

endmodule

bind lcd_seg_driver lcd_seg_driver_chk #(.COLS(COLS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .shift_clk   (shift_clk),
    .line_load   (line_load),
    .chain_dis_in(chain_dis_in),
    .chain_out   (chain_out),
    .alt         (alt),
    .blank_n     (blank_n),
    .drive_code  (drive_code)
);

// File: tb/sim_lcd_seg_driver.sv
module sim_lcd_seg_driver;

    localparam int COLS = 80;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              shift_clk, line_load, par_mode, ser_in;
    logic [3:0]        par_in;
    logic              chain_dis_in, chain_out, alt, blank_n;
    logic [2*COLS-1:0] drive_code;

    int errors = 0;
    int checks = 0;

    logic [COLS-1:0] m_l1 = '0;
    logic [COLS-1:0] m_l2 = '0;
    logic [3:0]      m_grp = '0;
    int              m_cnt = 0;

    logic [2*COLS-1:0] exp_q[$];
    string             tag_q[$];
    event              chk_ev;

    always #10 clk = ~clk;

    lcd_seg_driver #(.COLS(COLS)) u0 (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .line_load(line_load),
        .par_mode(par_mode), .ser_in(ser_in), .par_in(par_in),
        .chain_dis_in(chain_dis_in), .chain_out(chain_out),
        .alt(alt), .blank_n(blank_n), .drive_code(drive_code)
    );

    // Expected codes from the level table (R8, R9).
    function automatic logic [2*COLS-1:0] expand(input logic [COLS-1:0] l2);
        logic [2*COLS-1:0] e;
        for (int c = 0; c < COLS; c++) begin
            if (!blank_n) e[2*c +: 2] = 2'b00;
            else case ({alt, l2[c]})
                2'b01:   e[2*c +: 2] = 2'b00;
                2'b00:   e[2*c +: 2] = 2'b01;
                2'b11:   e[2*c +: 2] = 2'b10;
                default: e[2*c +: 2] = 2'b11;
            endcase
        end
        return e;
    endfunction

    task automatic chk_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Monitor: pop each expected output vector and compare with the ports.
    initial begin
        forever begin
            @(chk_ev);
            begin
                logic [2*COLS-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (drive_code !== e) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", t, drive_code, e);
                end
            end
        end
    end

    task automatic push_check(string req);
        exp_q.push_back(expand(m_l2));
        tag_q.push_back(req);
        ->chk_ev;
        #1;
    endtask

    task automatic send_ser(logic b, logic [3:0] junk);
        @(negedge clk); ser_in = b; par_in = junk; shift_clk = 1'b1;
        @(negedge clk); shift_clk = 1'b0;
        @(negedge clk);
        if (!chain_dis_in && m_cnt < COLS) begin
            m_grp[m_cnt % 4] = b;
            if (m_cnt % 4 == 3) m_l1[m_cnt-3 +: 4] = m_grp;
            m_cnt++;
        end
    endtask

    task automatic send_par(logic [3:0] g);
        @(negedge clk); par_in = g; shift_clk = 1'b1;
        @(negedge clk); shift_clk = 1'b0;
        @(negedge clk);
        if (!chain_dis_in && m_cnt < COLS) begin
            m_l1[(m_cnt/4)*4 +: 4] = g;
            m_cnt = (m_cnt/4 + 1) * 4;
        end
    endtask

    task automatic do_load(string req);
        @(negedge clk); line_load = 1'b1;
        @(negedge clk); line_load = 1'b0;
        @(negedge clk);
        m_l2 = m_l1;
        m_cnt = 0;
        push_check(req);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; shift_clk = 1'b0; line_load = 1'b0; par_mode = 1'b0;
        ser_in = 1'b0; par_in = 4'h0; chain_dis_in = 1'b0; alt = 1'b0; blank_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push_check("R1 reset codes");
        chk_bit("R1 chain after reset", chain_out, 1'b1);

        // R2: irregular serial line with noise on par_in.
        for (int i = 0; i < COLS; i++) begin
            send_ser(((i * 7 + 1) % 5) < 2, 4'(i * 3));
            if (i == COLS - 2) chk_bit("R5 chain before last bit", chain_out, 1'b1);
        end
        chk_bit("R5 chain after full line", chain_out, 1'b0);
        // R5: extra bits must not wrap.
        for (int i = 0; i < 4; i++) send_ser(1'b1, 4'hF);
        chk_bit("R5 chain stays low", chain_out, 1'b0);
        do_load("R2 serial order");
        chk_bit("R7 chain re-armed", chain_out, 1'b1);

        // R3: parallel line.
        par_mode = 1'b1;
        for (int i = 0; i < COLS / 4; i++) send_par(4'((i * 5 + 3) & 15));
        chk_bit("R3 chain after parallel line", chain_out, 1'b0);
        do_load("R3 parallel order");

        // R4: disabled chip ignores data.
        par_mode = 1'b0;
        chain_dis_in = 1'b1;
        for (int i = 0; i < 12; i++) send_ser(1'b1, 4'h0);
        chk_bit("R4 chain unchanged while disabled", chain_out, 1'b1);
        do_load("R4 disabled line ignored");
        chain_dis_in = 1'b0;

        // R6: 78-bit line leaves the last group untouched.
        for (int i = 0; i < COLS - 2; i++) send_ser(1'b0, 4'h9);
        do_load("R6 partial group dropped");

        // R7: load cleared fill position and partial group.
        send_ser(1'b1, 4'h0); send_ser(1'b1, 4'h0);
        send_ser(1'b0, 4'h0); send_ser(1'b1, 4'h0);
        do_load("R7 fill restarts at column 0");

        // R8 / R9: level selection.
        @(negedge clk); alt = 1'b1;  blank_n = 1'b1; push_check("R8 alt high");
        @(negedge clk); alt = 1'b1;  blank_n = 1'b0; push_check("R9 blank with alt high");
        @(negedge clk); alt = 1'b0;  blank_n = 1'b0; push_check("R9 blank with alt low");
        @(negedge clk); alt = 1'b0;  blank_n = 1'b1; push_check("R8 alt low");

        @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule